// File: doc/BRIEF.md
# BCD Mantissa Digit Shifter and Normalizer

The block holds two 12-digit packed BCD mantissas, X and Y, together with a 16-bit A word, a 16-bit B word and a decimal carry flag. The four low bits of A serve as a spare digit that moves into and out of a mantissa. The four low bits of B give a shift count, or receive one. A host starts one operation at a time with a strobe and an opcode. The block moves whole 4-bit digits, one digit per clock. It raises busy while it works and gives a one-cycle done pulse at the end.

Five operations exist. A load writes all state at once. A right shift of X or of Y moves the mantissa by a count of digits. A one-digit rotate moves Y left through the spare digit. A one-digit right shift of X ejects the lowest digit. Normalization shifts Y left until its leading digit is non-zero. It reports the number of shifts and flags a mantissa that is entirely zero. Signs, exponents and arithmetic belong to other blocks.

Digit 1 (most significant) sits in bits [47:44] of a mantissa and digit 12 (least significant) in bits [3:0]. Opcodes: 0 load, 1 right shift X by count, 2 right shift Y by count, 3 rotate Y left one digit, 4 right shift X one digit, 5 normalize Y; codes 6 and 7 are unused.

Top module: `bcd_digit_shifter`

## Requirements
- R1: Reset clears X, Y, A, B, carry, busy and done. Opcode 0 copies the load inputs into X, Y, A, B and the carry, and done rises right after the accepting edge.
- R2: For opcode 1 (X) or 2 (Y) with count n = B[3:0] ≥ 1, the first step puts A[3:0] into digit 1 and discards digit 12.
- R3: Every later step of a counted right shift zero-fills digit 1. The last step moves the outgoing digit 12 into A[3:0]. The resulting mantissa equals the low 48 bits of {A[3:0], M} shifted right by 4n bits, with n = 1 both injecting and ejecting.
- R4: After a counted right shift, A[15:4] and the carry are zero, and the other mantissa and B keep their values.
- R5: With count 0, opcodes 1 and 2 leave both mantissas and A[3:0] unchanged, clear A[15:4] and the carry, and finish right after the accepting edge.
- R6: Opcode 3 rotates {Y, A[3:0]} left by one digit: the old digit 1 goes to A[3:0] and the old A[3:0] becomes digit 12. A[15:4] and the carry are cleared.
- R7: Opcode 4 moves digit 12 of X into A[3:0], shifts X right one digit with a zero in digit 1, and clears A[15:4] and the carry.
- R8: Opcode 5 shifts Y left with zero fill until digit 1 is non-zero or 12 shifts are done. Zero shifts are done if digit 1 is already non-zero. B becomes the shift count with B[15:4] zero. The carry is set exactly when 12 shifts were done. X and A keep their values.
- R9: Digits move one per clock. Counting the accepting edge as edge 1, done is high after edge n+1 for a counted shift with n ≥ 1, after edge 2 for opcodes 3 and 4, and after edge k+2 for a normalize of k shifts.
- R10: Busy is high from the accepting edge until done rises, is low while done is high, and falls only together with done rising.
- R11: A strobe while busy is high is ignored and does not alter the running operation or its result.
- R12: A strobe with opcode 6 or 7 is ignored: no busy, no done and no change to any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation strobe, taken when busy is low |
| op_code | input | 3 | Operation select |
| ld_x | input | 48 | X value for the load operation |
| ld_y | input | 48 | Y value for the load operation |
| ld_a | input | 16 | A value for the load operation |
| ld_b | input | 16 | B value for the load operation |
| ld_carry | input | 1 | Carry value for the load operation |
| x_q | output | 48 | X mantissa |
| y_q | output | 48 | Y mantissa |
| a_q | output | 16 | A word; bits [3:0] are the spare digit |
| b_q | output | 16 | B word; bits [3:0] are the count |
| carry_q | output | 1 | Decimal carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The corners that are hardest to reach from the ports are the extremes of the step counter. One is a normalize that runs all twelve shifts on an all-zero Y and must set the carry. Another is a counted shift above twelve, where the injected digit must cross the whole mantissa and come back out into A. Random values seldom hit either, so directed loads set up exact mantissas: all zeros, a single non-zero last digit, and counts of 0, 1, 12 and 15. The random normalize stimulus also shifts random mantissas down by a random number of digits to spread the leading-zero counts. A strobe injected in the middle of a long shift exercises the rule that starts are ignored while busy.

// File: rtl/bcd_shift_pkg.sv
package bcd_shift_pkg;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_RSX  = 3'd1,
    OP_RSY  = 3'd2,
    OP_LSY  = 3'd3,
    OP_R1X  = 3'd4,
    OP_NORM = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_FIN
  } seq_state_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  function automatic logic op_counted(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2);
  endfunction

endpackage

// File: rtl/bcd_lane_shift.sv
module bcd_lane_shift #(
  parameter int unsigned DIGITS = 12,
  parameter int unsigned DIGW   = 4,
  localparam int unsigned MW    = DIGITS * DIGW
) (
  input  logic [MW-1:0]   m_i,
  input  logic            shl_i,
  input  logic [DIGW-1:0] fill_i,
  output logic [MW-1:0]   m_o,
  output logic [DIGW-1:0] eject_o
);

  function automatic logic [MW-1:0] toward_lsd(input logic [MW-1:0] m, input logic [DIGW-1:0] f);
    return {f, m[MW-1:DIGW]};
  endfunction

  function automatic logic [MW-1:0] toward_msd(input logic [MW-1:0] m, input logic [DIGW-1:0] f);
    return {m[MW-DIGW-1:0], f};
  endfunction

  always_comb begin
    if (shl_i) begin
      m_o     = toward_msd(m_i, fill_i);
      eject_o = m_i[MW-1 -: DIGW];
    end else begin
      m_o     = toward_lsd(m_i, fill_i);
      eject_o = m_i[DIGW-1:0];
    end
  end

endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
  import bcd_shift_pkg::*;
#(
  parameter int unsigned DIGITS = 12,
  parameter int unsigned CNTW   = 4,
  localparam int unsigned IW    = CNTW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      op_code_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic            y_lead_zero_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            load_o,
  output logic            zero_fin_o,
  output logic            step_o,
  output logic            first_o,
  output logic            last_o,
  output logic            norm_stop_o,
  output op_e             op_o,
  output logic [IW-1:0]   idx_o
);

  seq_state_e    state_q;
  op_e           op_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] total_q;
  logic          accept;
  logic          running;
  logic          is_norm;

  always_comb begin
    running     = (state_q == S_RUN);
    is_norm     = (op_q == OP_NORM);
    accept      = start_i && !running && op_known(op_code_i);
    load_o      = accept && (op_code_i == 3'd0);
    zero_fin_o  = accept && op_counted(op_code_i) && (cnt_i == '0);
    norm_stop_o = running && is_norm && (!y_lead_zero_i || (idx_q == IW'(DIGITS)));
    step_o      = running && !norm_stop_o;
    first_o     = step_o && (idx_q == '0);
    last_o      = step_o && !is_norm && ((idx_q + IW'(1)) == total_q);
    busy_o      = running;
    done_o      = (state_q == S_FIN);
    op_o        = op_q;
    idx_o       = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_LOAD;
      idx_q   <= '0;
      total_q <= '0;
    end else if (accept) begin
      op_q    <= op_e'(op_code_i);
      idx_q   <= '0;
      total_q <= op_counted(op_code_i) ? {1'b0, cnt_i} : IW'(1);
      state_q <= (load_o || zero_fin_o) ? S_FIN : S_RUN;
    end else begin
      if (step_o) idx_q <= idx_q + IW'(1);
      unique case (state_q)
        S_RUN:   if (last_o || norm_stop_o) state_q <= S_FIN;
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  // R12
  undefined_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !op_known(op_code_i)) |=> (!busy_o && !done_o));

endmodule

// File: rtl/bcd_digit_shifter.sv
module bcd_digit_shifter
  import bcd_shift_pkg::*;
#(
  parameter int unsigned DIGITS = 12,
  parameter int unsigned DIGW   = 4,
  parameter int unsigned WORD   = 16,
  parameter int unsigned CNTW   = 4,
  localparam int unsigned MW    = DIGITS * DIGW,
  localparam int unsigned IW    = CNTW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op_code,
  input  logic [MW-1:0]   ld_x,
  input  logic [MW-1:0]   ld_y,
  input  logic [WORD-1:0] ld_a,
  input  logic [WORD-1:0] ld_b,
  input  logic            ld_carry,
  output logic [MW-1:0]   x_q,
  output logic [MW-1:0]   y_q,
  output logic [WORD-1:0] a_q,
  output logic [WORD-1:0] b_q,
  output logic            carry_q,
  output logic            busy,
  output logic            done
);

  localparam int unsigned NLANE = 2;
  localparam int unsigned LX    = 0;
  localparam int unsigned LY    = 1;

  logic            load_ev, zero_fin_ev, step_ev, first_ev, last_ev, norm_stop_ev;
  op_e             op_run;
  logic [IW-1:0]   step_idx;
  logic [DIGW-1:0] a_dig;

  logic [MW-1:0]   lane_in    [NLANE];
  logic [MW-1:0]   lane_out   [NLANE];
  logic [DIGW-1:0] lane_fill  [NLANE];
  logic [DIGW-1:0] lane_eject [NLANE];
  logic            lane_left  [NLANE];

  function automatic logic [WORD-1:0] spare_word(input logic [DIGW-1:0] d);
    return {{(WORD-DIGW){1'b0}}, d};
  endfunction

  assign a_dig = a_q[DIGW-1:0];

  bcd_seq_ctrl #(.DIGITS(DIGITS), .CNTW(CNTW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .op_code_i     (op_code),
    .cnt_i         (b_q[CNTW-1:0]),
    .y_lead_zero_i (y_q[MW-1 -: DIGW] == '0),
    .busy_o        (busy),
    .done_o        (done),
    .load_o        (load_ev),
    .zero_fin_o    (zero_fin_ev),
    .step_o        (step_ev),
    .first_o       (first_ev),
    .last_o        (last_ev),
    .norm_stop_o   (norm_stop_ev),
    .op_o          (op_run),
    .idx_o         (step_idx)
  );

  always_comb begin
    lane_in[LX]   = x_q;
    lane_in[LY]   = y_q;
    lane_left[LX] = 1'b0;
    lane_left[LY] = (op_run == OP_LSY) || (op_run == OP_NORM);
    lane_fill[LX] = (op_run == OP_RSX && first_ev) ? a_dig : '0;
    lane_fill[LY] = ((op_run == OP_LSY) || (op_run == OP_RSY && first_ev)) ? a_dig : '0;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    bcd_lane_shift #(.DIGITS(DIGITS), .DIGW(DIGW)) u_lane (
      .m_i     (lane_in[g]),
      .shl_i   (lane_left[g]),
      .fill_i  (lane_fill[g]),
      .m_o     (lane_out[g]),
      .eject_o (lane_eject[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      a_q     <= '0;
      b_q     <= '0;
      carry_q <= 1'b0;
    end else if (load_ev) begin
      x_q     <= ld_x;
      y_q     <= ld_y;
      a_q     <= ld_a;
      b_q     <= ld_b;
      carry_q <= ld_carry;
    end else if (zero_fin_ev) begin
      a_q     <= spare_word(a_dig);
      carry_q <= 1'b0;
    end else if (step_ev) begin
      unique case (op_run)
        OP_RSX: begin
          x_q <= lane_out[LX];
          if (last_ev) begin
            a_q     <= spare_word(lane_eject[LX]);
            carry_q <= 1'b0;
          end
        end
        OP_RSY: begin
          y_q <= lane_out[LY];
          if (last_ev) begin
            a_q     <= spare_word(lane_eject[LY]);
            carry_q <= 1'b0;
          end
        end
        OP_LSY: begin
          y_q     <= lane_out[LY];
          a_q     <= spare_word(lane_eject[LY]);
          carry_q <= 1'b0;
        end
        OP_R1X: begin
          x_q     <= lane_out[LX];
          a_q     <= spare_word(lane_eject[LX]);
          carry_q <= 1'b0;
        end
        OP_NORM: y_q <= lane_out[LY];
        default: ;
      endcase
    end else if (norm_stop_ev) begin
      b_q     <= WORD'(step_idx[CNTW-1:0]);
      carry_q <= (step_idx == IW'(DIGITS));
    end
  end

  // R2
  rsx_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && first_ev && op_run == OP_RSX) |=> (x_q[MW-1 -: DIGW] == $past(a_dig)));

  // R3
  mid_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !first_ev && op_run == OP_RSY) |=> (y_q[MW-1 -: DIGW] == '0));

  // R4
  final_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ev && (op_run == OP_RSX || op_run == OP_RSY)) |=> (a_q[WORD-1:DIGW] == '0 && !carry_q));

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fin_ev |=> ($stable(x_q) && $stable(y_q) && a_dig == $past(a_dig) && !carry_q));

  // R6
  lsy_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && op_run == OP_LSY) |=> ({y_q, a_dig} ==
      {$past(y_q[MW-DIGW-1:0]), $past(a_dig), $past(y_q[MW-1 -: DIGW])}));

  // R8
  norm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_stop_ev |=> (b_q[WORD-1:CNTW] == '0 && carry_q == (y_q == '0)));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && op_run != OP_LOAD) |=> (op_run == $past(op_run)));

endmodule

// File: tb/tb_bcd_digit_shifter.sv
module tb_bcd_digit_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_code = '0;
  logic [47:0] ld_x = '0, ld_y = '0;
  logic [15:0] ld_a = '0, ld_b = '0;
  logic        ld_carry = 1'b0;
  logic [47:0] x_q, y_q;
  logic [15:0] a_q, b_q;
  logic        carry_q, busy, done;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          finished = 0;

  logic [47:0] mx, my;
  logic [15:0] ma, mb;
  logic        mc;

  always #5 clk = ~clk;

  bcd_digit_shifter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .ld_x(ld_x), .ld_y(ld_y), .ld_a(ld_a), .ld_b(ld_b), .ld_carry(ld_carry),
    .x_q(x_q), .y_q(y_q), .a_q(a_q), .b_q(b_q), .carry_q(carry_q),
    .busy(busy), .done(done)
  );

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    cmp(tag, "X", 64'(x_q), 64'(mx));
    cmp(tag, "Y", 64'(y_q), 64'(my));
    cmp(tag, "A", 64'(a_q), 64'(ma));
    cmp(tag, "B", 64'(b_q), 64'(mb));
    cmp(tag, "carry", 64'(carry_q), 64'(mc));
  endtask

  function automatic logic [47:0] rnd_bcd();
    logic [47:0] r = '0;
    for (int i = 0; i < 12; i++) r = {r[43:0], 4'($urandom_range(9, 0))};
    return r;
  endfunction

  task automatic issue(input logic [2:0] code, input bit intrude, output int lat, output bit busy_ok);
    @(negedge clk);
    op_code = code;
    start   = 1'b1;
    @(posedge clk); #1;
    start   = 1'b0;
    lat     = 0;
    busy_ok = 1'b1;
    while (!done && lat < 64) begin
      if (!busy) busy_ok = 1'b0;
      if (intrude && lat == 1) begin
        start = 1'b1; op_code = 3'd0;
        ld_x = ~ld_x; ld_y = ~ld_y; ld_a = 16'hFFFF; ld_b = 16'h0003;
      end else if (intrude && lat == 2) begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      lat++;
    end
    if (busy) busy_ok = 1'b0;
  endtask

  task automatic do_load(input logic [47:0] x, input logic [47:0] y, input logic [15:0] a,
                         input logic [15:0] b, input logic c);
    int lat; bit bok;
    ld_x = x; ld_y = y; ld_a = a; ld_b = b; ld_carry = c;
    issue(3'd0, 1'b0, lat, bok);
    mx = x; my = y; ma = a; mb = b; mc = c;
    check_state("R1");
    cmp("R1", "load latency", 64'(lat), 64'd0);
  endtask

  task automatic run_op(input logic [2:0] code, input bit intrude, input string tag);
    int lat, exp_lat, n, k;
    bit bok;
    logic [63:0] t;
    exp_lat = 0;
    n = int'(mb[3:0]);
    case (code)
      3'd1, 3'd2: begin
        if (n == 0) begin
          ma = {12'h000, ma[3:0]};
        end else begin
          t = {12'h000, ma[3:0], (code == 3'd1) ? mx : my};
          ma = {12'h000, 4'(t >> (4 * (n - 1)))};
          t = t >> (4 * n);
          if (code == 3'd1) mx = t[47:0]; else my = t[47:0];
          exp_lat = n;
        end
        mc = 1'b0;
      end
      3'd3: begin
        t = {12'h000, my, ma[3:0]};
        my = t[47:0];
        ma = {12'h000, t[51:48]};
        mc = 1'b0; exp_lat = 1;
      end
      3'd4: begin
        ma = {12'h000, mx[3:0]};
        mx = {4'h0, mx[47:4]};
        mc = 1'b0; exp_lat = 1;
      end
      default: begin
        k = 0;
        while (k < 12 && my[47:44] == 4'h0) begin my = my << 4; k++; end
        mb = 16'(k);
        mc = (k == 12);
        exp_lat = k + 1;
      end
    endcase
    issue(code, intrude, lat, bok);
    check_state(tag);
    cmp("R9", "latency", 64'(lat), 64'(exp_lat));
    cmp("R10", "busy shape", 64'(bok), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    mx = '0; my = '0; ma = '0; mb = '0; mc = 1'b0;
    check_state("R1");
    cmp("R1", "busy after reset", 64'(busy), 64'd0);
    cmp("R1", "done after reset", 64'(done), 64'd0);

    // R2: single step injects and ejects
    do_load(48'h123456789012, 48'h987654321098, 16'hABC7, 16'h0001, 1'b1);
    run_op(3'd1, 1'b0, "R2");
    // R3: two steps on X
    do_load(48'h123456789012, 48'h0, 16'h5555, 16'h0002, 1'b1);
    run_op(3'd1, 1'b0, "R3");
    // R3: full width and beyond: injected digit returns to A at count 13
    do_load(48'h987654321098, 48'h111111111111, 16'h0004, 16'h000C, 1'b0);
    run_op(3'd1, 1'b0, "R3");
    do_load(48'h987654321098, 48'h111111111111, 16'h0006, 16'h000D, 1'b0);
    run_op(3'd1, 1'b0, "R3");
    do_load(48'h987654321098, 48'h111111111111, 16'h0006, 16'h000F, 1'b1);
    run_op(3'd1, 1'b0, "R3");
    // R2 R4: Y counted shift leaves X and B alone
    do_load(48'h246802468024, 48'h135791357913, 16'hF0F8, 16'hA5A3, 1'b1);
    run_op(3'd2, 1'b0, "R2");
    cmp("R4", "A upper", 64'(a_q[15:4]), 64'd0);
    // R5: zero count
    do_load(48'h246802468024, 48'h135791357913, 16'hF0F8, 16'hA5A0, 1'b1);
    run_op(3'd2, 1'b0, "R5");
    do_load(48'h246802468024, 48'h135791357913, 16'h1239, 16'h0010, 1'b1);
    run_op(3'd1, 1'b0, "R5");
    // R6 R7
    do_load(48'h908070605040, 48'h712345678905, 16'hEEE3, 16'h0000, 1'b1);
    run_op(3'd3, 1'b0, "R6");
    run_op(3'd4, 1'b0, "R7");
    // R8: already normalized, single low digit, all zero
    do_load(48'h0, 48'h500000000001, 16'h4444, 16'hFFFF, 1'b1);
    run_op(3'd5, 1'b0, "R8");
    do_load(48'h0, 48'h000000000007, 16'h4444, 16'hFFFF, 1'b1);
    run_op(3'd5, 1'b0, "R8");
    do_load(48'h0, 48'h000000000000, 16'h4444, 16'h0000, 1'b0);
    run_op(3'd5, 1'b0, "R8");
    // R11: load strobe in the middle of a six-digit shift
    do_load(48'h314159265358, 48'h271828182845, 16'h0002, 16'h0006, 1'b0);
    run_op(3'd1, 1'b1, "R11");
    // R12: unused opcodes
    for (int c = 6; c < 8; c++) begin
      int quiet;
      @(negedge clk); op_code = 3'(c); start = 1'b1; ld_x = '1;
      @(negedge clk); start = 1'b0;
      quiet = 1;
      for (int w = 0; w < 3; w++) begin
        if (busy || done) quiet = 0;
        @(negedge clk);
      end
      cmp("R12", "no busy or done", 64'(quiet), 64'd1);
      check_state("R12");
    end
    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [2:0] code;
      logic [47:0] ry;
      code = 3'($urandom_range(5, 1));
      ry = rnd_bcd();
      if (code == 3'd5) ry = ry >> (4 * $urandom_range(12, 0));
      do_load(rnd_bcd(), ry, 16'($urandom), 16'($urandom_range(15, 0)) | 16'($urandom & 32'hFFF0),
              1'($urandom));
      case (code)
        3'd1, 3'd2: run_op(code, it[2], "R3");
        3'd3:       run_op(code, 1'b0, "R6");
        3'd4:       run_op(code, 1'b0, "R7");
        default:    run_op(code, it[3], "R8");
      endcase
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule